// File: doc/BRIEF.md
# Self-Timed Single-Wire Bus Slave

This block is the responding end of a one-wire, open-drain, half-duplex bus with a single initiator. It keeps no preset baud rate. Each exchange starts with a low attention pulse of any length. Next comes a low calibration pulse four bit periods long. The slave counts system clocks across that pulse and takes the bit period as the count divided by four. It samples each bit at the middle of its period. The rest of the frame is a fixed series of bit-period slots, timed from the rising edge that ends the calibration pulse: a high gap, eight address bits, a gap, eight data bits, a gap, an acknowledge slot, and a rest slot.

The address byte is sent MSB first. Its upper seven bits are compared with the configured address and with two reserved values. Its lowest bit selects read (1) or write (0). On a write the slave captures the data byte and pulses a strobe. On a read it shifts its transmit byte onto the wire. The slave only pulls the line low or releases it, so several slaves can answer the all-respond address together. The block's only output to the wire is a pull-low enable.

Top module: `swbus_slave`

## Requirements
- R1: After reset `driveLow` is 0, `wrValid` is 0 and `rxByte` is 0.
- R2: The attention low pulse may have any length. The bit period is the calibration low time in system clocks shifted right by two. Frames with different bit periods are all received correctly.
- R3: Address bits are taken MSB first. If the upper seven bits equal neither `myAddr`, nor 7'h00, nor 7'h7F, the slave never asserts `driveLow` and never pulses `wrValid` during that frame. `rxByte` keeps its previous value.
- R4: On a write (address bit 0 = 0) to a matching address, the eight data bits are sampled MSB first. `rxByte` then takes the byte, and `wrValid` is high for exactly one cycle after the last data bit.
- R5: On a read (address bit 0 = 1) to its own address, the slave drives `txByte` MSB first, one bit per slot. In each data slot `driveLow` is 1 exactly when that bit is 0.
- R6: After a write or read to its own address, the slave holds the line low through the acknowledge slot, which is the second slot after the last data bit.
- R7: Address 7'h00 is a broadcast. Write data is accepted with `wrValid`, but the slave never asserts `driveLow` in a 7'h00 frame, whether read or write.
- R8: Address 7'h7F is all-respond. The slave acknowledges writes and reads, and on a read it drives `txByte`.
- R9: If the calibration low time is shorter than 8 system clocks, the frame is dropped. The slave returns to idle without driving the line.
- R10: `driveLow` is only asserted while a frame is in progress, and never in the slot that follows the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Raw level of the bus wire (1 = released/high) |
| myAddr | input | 7 | Configured slave address |
| txByte | input | 8 | Byte returned on a read |
| driveLow | output | 1 | Pull-low enable for the open-drain driver |
| rxByte | output | 8 | Last byte received by a write |
| wrValid | output | 1 | One-cycle strobe when `rxByte` is updated |

## Verification
The hardest condition to reach from the ports is a calibration pulse too short to time by. If such a frame were not dropped, the slave would run a frame with a one-clock period and answer on its own. To reach it, the stimulus sends an attention pulse and then a six-clock low pulse, and holds the line high. Frame timing under this condition reads an all-ones address, the all-respond read, so a faulty slave would pull the wire low. A monitor watches for any drive in that window, and a normal frame that follows must still complete. The slave's own drive loops back onto its input through the wired line. The bench therefore models the bus as the initiator's level ANDed with the inverted pull-low, so that reads and acknowledges are observed the way an initiator would see them.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

  localparam int SLOT_W = 5;
  typedef logic [SLOT_W-1:0] slot_t;

  // Slot numbering after the calibration pulse ends
  localparam slot_t SLOT_ADDR_FIRST = 5'd1;
  localparam slot_t SLOT_ADDR_LAST  = 5'd8;
  localparam slot_t SLOT_DATA_FIRST = 5'd10;
  localparam slot_t SLOT_DATA_LAST  = 5'd17;
  localparam slot_t SLOT_ACK        = 5'd19;
  localparam slot_t SLOT_REST       = 5'd20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ATTN,
    ST_GAP,
    ST_CAL,
    ST_FRAME
  } state_e;

  typedef struct packed {
    logic calStart;
    logic calInc;
    logic calEnd;
    logic frameRun;
  } ctl_t;

endpackage

// File: rtl/swbus_ctrl.sv
module swbus_ctrl
  import swbus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   lineS,
  input  logic   calShort,
  input  logic   frameDone,
  output ctl_t   ctl
);

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE:  if (!lineS) stateNext = ST_ATTN;
      ST_ATTN:  if (lineS)  stateNext = ST_GAP;
      ST_GAP: begin
        if (!lineS) begin
          ctl.calStart = 1'b1;
          stateNext    = ST_CAL;
        end
      end
      ST_CAL: begin
        if (lineS) begin
          ctl.calEnd = 1'b1;
          stateNext  = calShort ? ST_IDLE : ST_FRAME;
        end else begin
          ctl.calInc = 1'b1;
        end
      end
      ST_FRAME: begin
        ctl.frameRun = 1'b1;
        if (frameDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/swbus_dp.sv
module swbus_dp
  import swbus_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_CAL     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] myAddr,
  input  logic [DATA_W-1:0] txByte,
  output logic              lineS,
  output logic              calShort,
  output logic              frameDone,
  output logic [ADDR_W-1:0] addrHi,
  output logic              rwBit,
  output logic              matchFlag,
  output logic              speakEn,
  output logic              driveLow,
  output logic [DATA_W-1:0] rxByte,
  output logic              wrValid
);

  localparam int PW = CNT_W - 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_BCAST = '0;
  localparam logic [ADDR_W-1:0] ADDR_ALL   = {ADDR_W{1'b1}};

  // Input synchroniser chain
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= lineIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate
  assign lineS = syncQ[SYNC_STAGES-1];

  // Calibration pulse measurement
  logic [CNT_W-1:0] calCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             calCnt <= '0;
    else if (ctl.calStart)                 calCnt <= CNT_W'(1);
    else if (ctl.calInc && calCnt != CNT_MAX) calCnt <= calCnt + 1'b1;
  end
  assign calShort = (calCnt < CNT_W'(MIN_CAL));

  // Slot timing
  logic [PW-1:0] period, half, phase;
  slot_t         slot;
  logic          slotEnd, midTick;

  assign slotEnd   = (phase == period - 1'b1);
  assign midTick   = ctl.frameRun && (phase == half);
  assign frameDone = slotEnd && (slot == SLOT_REST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period <= '0;
      half   <= '0;
      phase  <= '0;
      slot   <= '0;
    end else if (ctl.calEnd && !calShort) begin
      period <= calCnt[CNT_W-1:2];
      half   <= {1'b0, calCnt[CNT_W-1:3]};
      phase  <= '0;
      slot   <= '0;
    end else if (ctl.frameRun) begin
      if (slotEnd) begin
        phase <= '0;
        slot  <= slot + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  logic inAddr, inData;
  assign inAddr = (slot >= SLOT_ADDR_FIRST) && (slot <= SLOT_ADDR_LAST);
  assign inData = (slot >= SLOT_DATA_FIRST) && (slot <= SLOT_DATA_LAST);

  // Address / data shift registers
  logic [ADDR_W:0]   addrSh;
  logic [DATA_W-1:0] dataSh, txSh;
  logic              addrHit;

  assign addrHi  = addrSh[ADDR_W:1];
  assign rwBit   = addrSh[0];
  assign addrHit = (addrHi == myAddr) || (addrHi == ADDR_BCAST) || (addrHi == ADDR_ALL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSh    <= '0;
      dataSh    <= '0;
      txSh      <= '0;
      matchFlag <= 1'b0;
      speakEn   <= 1'b0;
    end else begin
      if (ctl.calEnd) begin
        matchFlag <= 1'b0;
        speakEn   <= 1'b0;
      end
      if (midTick && inAddr) addrSh <= {addrSh[ADDR_W-1:0], lineS};
      if (midTick && inData) dataSh <= {dataSh[DATA_W-2:0], lineS};
      if (ctl.frameRun && slotEnd && slot == SLOT_ADDR_LAST) begin
        matchFlag <= addrHit;
        speakEn   <= addrHit && (addrHi != ADDR_BCAST);
        txSh      <= txByte;
      end else if (ctl.frameRun && slotEnd && inData) begin
        txSh <= {txSh[DATA_W-2:0], 1'b1};
      end
    end
  end

  // Outputs
  logic driveNext;
  always_comb begin
    driveNext = 1'b0;
    if (ctl.frameRun && speakEn) begin
      if (inData && rwBit)    driveNext = ~txSh[DATA_W-1];
      if (slot == SLOT_ACK)   driveNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveLow <= 1'b0;
      rxByte   <= '0;
      wrValid  <= 1'b0;
    end else begin
      driveLow <= driveNext;
      wrValid  <= 1'b0;
      if (ctl.frameRun && slotEnd && slot == SLOT_DATA_LAST && matchFlag && !rwBit) begin
        rxByte  <= dataSh;
        wrValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/swbus_slave.sv
module swbus_slave
  import swbus_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CAL = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  input  logic [6:0] myAddr,
  input  logic [7:0] txByte,
  output logic       driveLow,
  output logic [7:0] rxByte,
  output logic       wrValid
);

  ctl_t       ctl;
  logic       lineS, calShort, frameDone;
  logic [6:0] addrHi;
  logic       rwBit, matchFlag, speakEn;

  swbus_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineS     (lineS),
    .calShort  (calShort),
    .frameDone (frameDone),
    .ctl       (ctl)
  );

  swbus_dp #(
    .CNT_W       (CNT_W),
    .MIN_CAL     (MIN_CAL),
    .SYNC_STAGES (2),
    .ADDR_W      (7),
    .DATA_W      (8)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .ctl       (ctl),
    .myAddr    (myAddr),
    .txByte    (txByte),
    .lineS     (lineS),
    .calShort  (calShort),
    .frameDone (frameDone),
    .addrHi    (addrHi),
    .rwBit     (rwBit),
    .matchFlag (matchFlag),
    .speakEn   (speakEn),
    .driveLow  (driveLow),
    .rxByte    (rxByte),
    .wrValid   (wrValid)
  );

endmodule

// File: rtl/swbus_slave_chk.sv
module swbus_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       driveLow,
  input logic       wrValid,
  input logic       frameRun,
  input logic       calEnd,
  input logic       calShort,
  input logic       matchFlag,
  input logic       rwBit,
  input logic [6:0] addrHi
);

  a_r4_wr_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  a_r4_wr_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !rwBit);

  a_r3_drive_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> matchFlag);

  a_r7_bcast_silent: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> (addrHi != 7'h00));

  a_r9_short_cal_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (calEnd && calShort) |=> !frameRun);

  a_r10_drive_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> frameRun);

endmodule

bind swbus_slave swbus_slave_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .driveLow  (driveLow),
  .wrValid   (wrValid),
  .frameRun  (ctl.frameRun),
  .calEnd    (ctl.calEnd),
  .calShort  (calShort),
  .matchFlag (matchFlag),
  .rwBit     (rwBit),
  .addrHi    (addrHi)
);

// File: tb/tb_swbus_slave.sv
module tb_swbus_slave;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mLevel = 1'b1;
  logic       lineIn;
  logic [6:0] myAddr = 7'h2B;
  logic [7:0] txByte = 8'h00;
  logic       driveLow;
  logic [7:0] rxByte;
  logic       wrValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit sawDrive = 1'b0;
  logic [7:0] expQ[$];

  always #5 clk = ~clk;

  assign lineIn = mLevel & ~driveLow;

  swbus_slave dut (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .myAddr   (myAddr),
    .txByte   (txByte),
    .driveLow (driveLow),
    .rxByte   (rxByte),
    .wrValid  (wrValid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each write strobe against the queued byte
  always @(negedge clk) begin
    if (driveLow) sawDrive = 1'b1;
    if (rstN && wrValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R3/R4 unexpected wrValid", rxByte, 0);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        chk(rxByte == e, "R4 rxByte on strobe", rxByte, e);
      end
    end
  end

  task automatic hold(input logic lvl, input int n);
    mLevel = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int p, input int attn, input logic [6:0] a, input logic rw,
                       input logic [7:0] wdata, input bit expectWr,
                       output logic [7:0] rdata, output logic ackSeen);
    logic [7:0] ab;
    ab = {a, rw};
    rdata = 8'h00;
    if (expectWr) expQ.push_back(wdata);
    hold(1'b0, attn);
    hold(1'b1, p);
    hold(1'b0, 4 * p);
    hold(1'b1, p);
    for (int i = 7; i >= 0; i--) hold(ab[i], p);
    hold(1'b1, p);
    if (!rw) begin
      for (int i = 7; i >= 0; i--) hold(wdata[i], p);
    end else begin
      mLevel = 1'b1;
      for (int i = 7; i >= 0; i--) begin
        repeat (p / 2) @(negedge clk);
        rdata[i] = lineIn;
        repeat (p - p / 2) @(negedge clk);
      end
    end
    hold(1'b1, p);
    mLevel = 1'b1;
    repeat (p / 2) @(negedge clk);
    ackSeen = !lineIn;
    repeat (p - p / 2) @(negedge clk);
    hold(1'b1, 3 * p);
  endtask

  initial begin
    logic [7:0] rd;
    logic       ack;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    chk(driveLow == 1'b0, "R1 driveLow at reset", driveLow, 0);
    chk(wrValid == 1'b0, "R1 wrValid at reset", wrValid, 0);
    chk(rxByte == 8'h00, "R1 rxByte at reset", rxByte, 0);
    rstN = 1'b1;
    hold(1'b1, 20);

    // R2/R4/R6: write to own address, short attention, period 16
    frame(16, 16, 7'h2B, 1'b0, 8'hA5, 1'b1, rd, ack);
    chk(ack, "R6 ack on own write", ack, 1);
    chk(expQ.size() == 0, "R4 write strobe seen (p16)", expQ.size(), 0);

    // R2: long attention, period 40
    frame(40, 200, 7'h2B, 1'b0, 8'h3C, 1'b1, rd, ack);
    chk(ack, "R2 ack with long attention p40", ack, 1);
    chk(expQ.size() == 0 && rxByte == 8'h3C, "R2 rxByte p40", rxByte, 8'h3C);

    // R5/R6: read own address
    txByte = 8'hC3;
    frame(20, 20, 7'h2B, 1'b1, 8'h00, 1'b0, rd, ack);
    chk(rd == 8'hC3, "R5 read data", rd, 8'hC3);
    chk(ack, "R6 ack on own read", ack, 1);

    // R3: write to other address
    keep = rxByte;
    sawDrive = 1'b0;
    frame(16, 16, 7'h15, 1'b0, 8'h00, 1'b0, rd, ack);
    chk(!sawDrive, "R3 no drive for foreign write", sawDrive, 0);
    chk(rxByte == keep, "R3 rxByte kept", rxByte, keep);

    // R3: read from other address
    sawDrive = 1'b0;
    frame(16, 16, 7'h2A, 1'b1, 8'h00, 1'b0, rd, ack);
    chk(rd == 8'hFF && !ack, "R3 foreign read undriven", rd, 8'hFF);

    // R7: broadcast write and read
    sawDrive = 1'b0;
    frame(24, 24, 7'h00, 1'b0, 8'h5A, 1'b1, rd, ack);
    chk(!ack && !sawDrive, "R7 no ack for broadcast", ack, 0);
    chk(expQ.size() == 0 && rxByte == 8'h5A, "R7 broadcast write accepted", rxByte, 8'h5A);
    sawDrive = 1'b0;
    frame(24, 24, 7'h00, 1'b1, 8'h00, 1'b0, rd, ack);
    chk(!sawDrive && rd == 8'hFF, "R7 broadcast read silent", rd, 8'hFF);

    // R8: all-respond write and read
    frame(18, 18, 7'h7F, 1'b0, 8'h81, 1'b1, rd, ack);
    chk(ack && expQ.size() == 0, "R8 all-respond write ack", ack, 1);
    txByte = 8'h6E;
    frame(18, 18, 7'h7F, 1'b1, 8'h00, 1'b0, rd, ack);
    chk(rd == 8'h6E, "R8 all-respond read data", rd, 8'h6E);
    chk(ack, "R8 all-respond read ack", ack, 1);

    // R9: too-short calibration pulse, then line held high
    txByte = 8'h00;
    sawDrive = 1'b0;
    hold(1'b0, 10);
    hold(1'b1, 10);
    hold(1'b0, 6);
    hold(1'b1, 120);
    chk(!sawDrive, "R9 short calibration dropped", sawDrive, 0);
    frame(16, 16, 7'h2B, 1'b0, 8'h0F, 1'b1, rd, ack);
    chk(ack && rxByte == 8'h0F, "R9 recovery frame", rxByte, 8'h0F);

    // R10: no drive after frame end
    sawDrive = 1'b0;
    hold(1'b1, 100);
    chk(!sawDrive, "R10 idle no drive", sawDrive, 0);
    chk(expQ.size() == 0, "R4 scoreboard empty", expQ.size(), 0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule